// File: doc/BRIEF.md
# Path-Signature Write-Back Predictor

This block sits beside a core's retirement stage and tries to name a persistent-memory write-back before it happens. It keeps a signature of the recent control path: the XOR of the last 32 retired program counters. Each time a PC retires, the updated signature goes out to an external prediction table, and the table answers in the same cycle. A hit that is confident about the address arms a watch for the store PC the table names. When that store retires, its address and value are captured. A precompute request then goes to the persistent-memory support engine (an encrypt or hash unit), so that the engine's work is under way before the real write-back reaches it.

Data that is hard to predict is handled in two ways. A table entry can mark the value as the common zero value, in which case the request carries zero as confident data. An entry that is confident only about the address sends the request with the data-valid flag clear. A watch that sees no matching store within `TIMEOUT` cycles lapses.

The request leaves on a valid/ready stream. A request stays on the port, unchanged, until a cycle in which `req_ready` is high. There is a single holding slot. A prediction that arrives while that slot is blocked is discarded and counted.

Top module: `pm_write_predictor`

## Requirements
- R1: `tbl_sig` equals the XOR of the most recent `HIST_DEPTH` (default 32) retired PCs, or of all PCs retired since reset if there are fewer. It is zero after reset and changes only in the cycle after a retire.
- R2: `lookup_valid` is high in exactly the cycles that follow a cycle with `retire_valid` high. In such a cycle `tbl_sig` already includes that PC. The table inputs are used only in these cycles.
- R3: A lookup with `tbl_hit` and `tbl_addr_ok` both high arms a watch for `tbl_store_pc`, and a newer arming replaces the current one. A miss, or a hit with `tbl_addr_ok` low, arms nothing. A later store then yields no request.
- R4: A store that retires while a watch is armed and whose `store_pc` equals the watched PC ends the watch. It yields a request in the next cycle carrying `store_addr`. Each watch captures at most once.
- R5: The request data follows the table entry's confidence:
  - `tbl_data_ok` high and `tbl_zero` low: `req_data` is `store_data` and `req_data_valid` is 1.
  - `tbl_data_ok` high and `tbl_zero` high: `req_data` is 0 and `req_data_valid` is 1.
  - `tbl_data_ok` low: `req_data` is 0 and `req_data_valid` is 0.
- R6: A watch stays armed for at most `TIMEOUT` cycles, counting the first cycle after the lookup as cycle 1. A matching store in cycle `TIMEOUT` is still captured. A matching store after that cycle is not.
- R7: While `req_valid` is high and `req_ready` is low, the request fields hold steady. The request is consumed at the first clock edge at which `req_ready` is high. `req_valid` then falls unless a new capture loads the slot in that same cycle.
- R8: A capture that arrives while the slot is valid and `req_ready` is low is discarded. `drop_count` then increases by one, saturating at its maximum value.
- R9: After reset `req_valid`, `lookup_valid` and `drop_count` are 0 and no watch is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_valid | input | 1 | A PC retires this cycle |
| retire_pc | input | PC_W | Retired PC |
| store_valid | input | 1 | A store retires this cycle |
| store_pc | input | PC_W | PC of the retiring store |
| store_addr | input | ADDR_W | Store address |
| store_data | input | DATA_W | Store value |
| tbl_sig | output | PC_W | Path signature used as the table lookup key |
| lookup_valid | output | 1 | The table answer is used this cycle |
| tbl_hit | input | 1 | Table entry matches the signature |
| tbl_store_pc | input | PC_W | Store PC named by the entry |
| tbl_addr_ok | input | 1 | Entry is address-confident |
| tbl_data_ok | input | 1 | Entry is data-confident |
| tbl_zero | input | 1 | Entry predicts the zero value |
| req_valid | output | 1 | Precompute request valid |
| req_ready | input | 1 | Support engine accepts the request |
| req_addr | output | ADDR_W | Predicted write-back address |
| req_data | output | DATA_W | Predicted write-back data |
| req_data_valid | output | 1 | `req_data` is a usable prediction |
| drop_count | output | CNT_W | Saturating count of discarded predictions |

## Verification
Some rules are checked on every cycle by the assertions:
- the signature holds between retires;
- `lookup_valid` trails `retire_valid` by one cycle;
- a watch's timer stays under `TIMEOUT` and a watch captures only once;
- a blocked request holds steady, with zero data whenever its data flag is clear;
- the drop counter only ever steps by one.

Other behaviour shows only in the bench's scenarios, compared cycle by cycle against a behavioural model:
- the 32-deep window wrapping, with the signature rebuilt from a PC queue;
- the three data-confidence cases;
- a hit without address confidence being ignored;
- the exact last cycle of the timeout window;
- a newer prediction dropped while the slot is back-pressured.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  typedef enum logic [1:0] {
    SLOT_KEEP,
    SLOT_LOAD,
    SLOT_DROP,
    SLOT_FREE
  } slot_act_e;
endpackage

// File: rtl/pwp_path_sig.sv
module pwp_path_sig #(
  parameter int PC_W       = 32,
  parameter int HIST_DEPTH = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PC_W-1:0] in_pc,
  output logic [PC_W-1:0] sig,
  output logic            lookup_valid
);
  localparam int LAST = HIST_DEPTH - 1;

  logic [HIST_DEPTH-1:0][PC_W-1:0] hist;
  logic [PC_W-1:0]                 leaving;

  generate
    if (HIST_DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist <= '0;
        else if (in_valid) hist[0] <= in_pc;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist <= '0;
        end else if (in_valid) begin
          hist[0] <= in_pc;
          for (int i = 1; i < HIST_DEPTH; i++) hist[i] <= hist[i-1];
        end
      end
    end
  endgenerate

  assign leaving = hist[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig          <= '0;
      lookup_valid <= 1'b0;
    end else begin
      lookup_valid <= in_valid;
      if (in_valid) sig <= sig ^ in_pc ^ leaving;
    end
  end

  // R1: the signature moves only on a retire
  a_r1_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(sig));
  // R2: a lookup follows every retire, and only a retire
  a_r2_lookup_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> lookup_valid);
  a_r2_no_spurious_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !lookup_valid);
endmodule

// File: rtl/pwp_watch.sv
module pwp_watch #(
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookup_valid,
  input  logic              tbl_hit,
  input  logic [PC_W-1:0]   tbl_store_pc,
  input  logic              tbl_addr_ok,
  input  logic              tbl_data_ok,
  input  logic              tbl_zero,
  input  logic              store_valid,
  input  logic [PC_W-1:0]   store_pc,
  input  logic [ADDR_W-1:0] store_addr,
  input  logic [DATA_W-1:0] store_data,
  output logic              cap_valid,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_dv
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(TIMEOUT - 1);

  logic            armed;
  logic [PC_W-1:0] tgt_pc;
  logic            tgt_data_ok;
  logic            tgt_zero;
  logic [TW-1:0]   timer;
  logic            arm;

  assign arm       = lookup_valid && tbl_hit && tbl_addr_ok;
  assign cap_valid = armed && store_valid && (store_pc == tgt_pc);
  assign cap_addr  = store_addr;
  assign cap_dv    = tgt_data_ok;
  assign cap_data  = (tgt_data_ok && !tgt_zero) ? store_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      tgt_pc      <= '0;
      tgt_data_ok <= 1'b0;
      tgt_zero    <= 1'b0;
      timer       <= '0;
    end else if (arm) begin
      armed       <= 1'b1;
      tgt_pc      <= tbl_store_pc;
      tgt_data_ok <= tbl_data_ok;
      tgt_zero    <= tbl_zero;
      timer       <= '0;
    end else if (cap_valid) begin
      armed <= 1'b0;
    end else if (armed) begin
      if (timer == LAST_TICK) armed <= 1'b0;
      else                    timer <= timer + 1'b1;
    end
  end

  // R6: an armed watch never outlives its window
  a_r6_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (timer < TW'(TIMEOUT)));
  // R4: a watch captures at most once unless re-armed
  a_r4_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !arm) |=> !cap_valid);
endmodule

// File: rtl/pwp_req_slot.sv
module pwp_req_slot
  import pwp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              cap_dv,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              req_data_valid,
  output logic [CNT_W-1:0]  drop_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  slot_act_e act;
  logic      blocked;

  assign blocked = req_valid && !req_ready;

  always_comb begin
    if (cap_valid)      act = blocked ? SLOT_DROP : SLOT_LOAD;
    else if (req_ready) act = SLOT_FREE;
    else                act = SLOT_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid      <= 1'b0;
      req_addr       <= '0;
      req_data       <= '0;
      req_data_valid <= 1'b0;
      drop_count     <= '0;
    end else begin
      unique case (act)
        SLOT_LOAD: begin
          req_valid      <= 1'b1;
          req_addr       <= cap_addr;
          req_data       <= cap_data;
          req_data_valid <= cap_dv;
        end
        SLOT_DROP: if (drop_count != CNT_MAX) drop_count <= drop_count + 1'b1;
        SLOT_FREE: req_valid <= 1'b0;
        default: ;
      endcase
    end
  end

  // R7: a blocked request holds every field
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                   && $stable(req_data) && $stable(req_data_valid)));
  // R5: an address-only request carries zero data
  a_r5_addr_only_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_data_valid) |-> (req_data == '0));
  // R8: the drop counter only steps by one
  a_r8_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count == $past(drop_count) || drop_count == $past(drop_count) + 1'b1));
endmodule

// File: rtl/pm_write_predictor.sv
module pm_write_predictor #(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int HIST_DEPTH = 32,
  parameter int TIMEOUT    = 64,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_valid,
  input  logic [PC_W-1:0]   retire_pc,
  input  logic              store_valid,
  input  logic [PC_W-1:0]   store_pc,
  input  logic [ADDR_W-1:0] store_addr,
  input  logic [DATA_W-1:0] store_data,
  output logic [PC_W-1:0]   tbl_sig,
  output logic              lookup_valid,
  input  logic              tbl_hit,
  input  logic [PC_W-1:0]   tbl_store_pc,
  input  logic              tbl_addr_ok,
  input  logic              tbl_data_ok,
  input  logic              tbl_zero,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              req_data_valid,
  output logic [CNT_W-1:0]  drop_count
);
  logic              cap_valid;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              cap_dv;

  pwp_path_sig #(.PC_W(PC_W), .HIST_DEPTH(HIST_DEPTH)) u_sig (
    .clk(clk), .rst_n(rst_n), .in_valid(retire_valid), .in_pc(retire_pc),
    .sig(tbl_sig), .lookup_valid(lookup_valid)
  );

  pwp_watch #(.PC_W(PC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_watch (
    .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid),
    .tbl_hit(tbl_hit), .tbl_store_pc(tbl_store_pc), .tbl_addr_ok(tbl_addr_ok),
    .tbl_data_ok(tbl_data_ok), .tbl_zero(tbl_zero),
    .store_valid(store_valid), .store_pc(store_pc), .store_addr(store_addr),
    .store_data(store_data),
    .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_data(cap_data), .cap_dv(cap_dv)
  );

  pwp_req_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_addr(cap_addr),
    .cap_data(cap_data), .cap_dv(cap_dv), .req_ready(req_ready),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .req_data_valid(req_data_valid), .drop_count(drop_count)
  );

  // R9: the request port stays quiet through reset
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!req_valid || rst_n));
endmodule

// File: tb/test_pm_write_predictor.sv
module test_pm_write_predictor;
  localparam int PC_W = 32, ADDR_W = 32, DATA_W = 64;
  localparam int HD = 32, TO = 8, CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire_valid = 0, store_valid = 0, req_ready = 1;
  logic [PC_W-1:0] retire_pc = '0, store_pc = '0, tbl_store_pc = '0;
  logic [ADDR_W-1:0] store_addr = '0;
  logic [DATA_W-1:0] store_data = '0;
  logic tbl_hit = 0, tbl_addr_ok = 0, tbl_data_ok = 0, tbl_zero = 0;
  logic [PC_W-1:0] tbl_sig;
  logic lookup_valid, req_valid, req_data_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic [CW-1:0] drop_count;

  always #10 clk = ~clk;

  pm_write_predictor #(.PC_W(PC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .HIST_DEPTH(HD), .TIMEOUT(TO), .CNT_W(CW)) i_pm_write_predictor (.*);

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [PC_W-1:0] hq[$];
  logic [PC_W-1:0] m_sig;
  bit m_look, m_armed, m_dok, m_zero, m_rv, m_rdv;
  logic [PC_W-1:0] m_tgt;
  int m_timer, m_drop;
  logic [ADDR_W-1:0] m_ra;
  logic [DATA_W-1:0] m_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      hq.delete(); m_sig = '0; m_look = 0; m_armed = 0; m_rv = 0; m_drop = 0;
      m_timer = 0; m_tgt = '0; m_dok = 0; m_zero = 0; m_rdv = 0; m_ra = '0; m_rd = '0;
    end else begin
      bit cap;
      logic [DATA_W-1:0] cd;
      cap = m_armed && store_valid && (store_pc == m_tgt);
      cd = (m_dok && !m_zero) ? store_data : '0;
      if (cap) begin
        if (m_rv && !req_ready) begin
          if (m_drop < 255) m_drop++;
        end else begin
          m_rv = 1; m_ra = store_addr; m_rd = cd; m_rdv = m_dok;
        end
      end else if (req_ready) m_rv = 0;
      if (m_look && tbl_hit && tbl_addr_ok) begin
        m_armed = 1; m_tgt = tbl_store_pc; m_dok = tbl_data_ok; m_zero = tbl_zero; m_timer = 0;
      end else if (cap) m_armed = 0;
      else if (m_armed) begin
        if (m_timer == TO - 1) m_armed = 0; else m_timer++;
      end
      m_look = retire_valid;
      if (retire_valid) begin
        hq.push_front(retire_pc);
        if (hq.size() > HD) void'(hq.pop_back());
        m_sig = '0;
        foreach (hq[i]) m_sig ^= hq[i];
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(tbl_sig == m_sig, "R1 sig", 64'(tbl_sig), 64'(m_sig));
    chk(lookup_valid == m_look, "R2 lookup", 64'(lookup_valid), 64'(m_look));
    chk(req_valid == m_rv, "R7 req_valid", 64'(req_valid), 64'(m_rv));
    if (m_rv) begin
      chk(req_addr == m_ra, "R4 req_addr", 64'(req_addr), 64'(m_ra));
      chk(req_data == m_rd, "R5 req_data", req_data, m_rd);
      chk(req_data_valid == m_rdv, "R5 data_valid", 64'(req_data_valid), 64'(m_rdv));
    end
    chk(32'(drop_count) == m_drop, "R8 drop_count", 64'(drop_count), 64'(m_drop));
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic retire(input logic [PC_W-1:0] pc, input bit hit, input logic [PC_W-1:0] tpc,
                        input bit aok, input bit dok, input bit z);
    retire_valid = 1; retire_pc = pc;
    tbl_hit = hit; tbl_store_pc = tpc; tbl_addr_ok = aok; tbl_data_ok = dok; tbl_zero = z;
    step();
    retire_valid = 0;
    step();
    tbl_hit = 0; tbl_addr_ok = 0; tbl_data_ok = 0; tbl_zero = 0;
  endtask

  task automatic store(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    store_valid = 1; store_pc = pc; store_addr = a; store_data = d;
    step();
    store_valid = 0;
  endtask

  initial begin
    fork
      begin
        step(3);
        // R9: reset state
        chk(req_valid == 0, "R9 req_valid", 64'(req_valid), 0);
        chk(drop_count == 0 && lookup_valid == 0 && tbl_sig == 0, "R9 idle outputs",
            64'(drop_count), 0);
        rst_n = 1;
        step(2);
        // R1: fill past the window, with gaps between retires
        for (int k = 0; k < 45; k++) begin
          retire_valid = 1; retire_pc = 32'h1000 + k * 32'h37;
          step();
          if (k % 4 == 3) begin retire_valid = 0; step(); end
        end
        retire_valid = 0; step(2);
        // R4/R5: fully confident; a wrong store is ignored, then the named one captures
        retire(32'hA0, 1, 32'h500, 1, 1, 0);
        store(32'h504, 32'hDEAD, 64'h11);
        store(32'h500, 32'hBEEF, 64'h1234_5678_9ABC);
        chk(req_valid && req_addr == 32'hBEEF, "R4 capture", 64'(req_addr), 64'hBEEF);
        chk(req_data == 64'h1234_5678_9ABC && req_data_valid, "R5 data", req_data, 64'h1234_5678_9ABC);
        step();
        store(32'h500, 32'hBEEF, 64'h1);
        chk(req_valid == 0, "R4 single capture", 64'(req_valid), 0);
        // R5: zero-value prediction
        retire(32'hA4, 1, 32'h600, 1, 1, 1);
        store(32'h600, 32'h40, 64'hFFFF);
        chk(req_data == 0 && req_data_valid == 1, "R5 zero", req_data, 0);
        step();
        // R5: address-only prediction
        retire(32'hA8, 1, 32'h700, 1, 0, 0);
        store(32'h700, 32'h80, 64'h77);
        chk(req_valid && req_data_valid == 0 && req_data == 0, "R5 addr only", 64'(req_data_valid), 0);
        step();
        // R3: a hit without address confidence arms nothing
        retire(32'hAC, 1, 32'h800, 0, 1, 0);
        store(32'h800, 32'h90, 64'h5);
        chk(req_valid == 0, "R3 no addr conf", 64'(req_valid), 0);
        // R3: a newer arming replaces the older one
        retire(32'hB0, 1, 32'h810, 1, 1, 0);
        retire(32'hB4, 1, 32'h820, 1, 1, 0);
        store(32'h810, 32'h91, 64'h6);
        chk(req_valid == 0, "R3 replaced", 64'(req_valid), 0);
        store(32'h820, 32'h92, 64'h7);
        chk(req_valid == 1 && req_addr == 32'h92, "R3 new target", 64'(req_addr), 64'h92);
        step();
        // R6: a store in the last armed cycle is captured
        retire(32'hB8, 1, 32'h900, 1, 1, 0);
        step(TO - 1);
        store(32'h900, 32'hA0, 64'h8);
        chk(req_valid == 1, "R6 last cycle", 64'(req_valid), 1);
        step();
        // R6: one cycle later the watch has lapsed
        retire(32'hBC, 1, 32'h910, 1, 1, 0);
        step(TO);
        store(32'h910, 32'hA4, 64'h9);
        chk(req_valid == 0, "R6 expired", 64'(req_valid), 0);
        // R7/R8: back-pressure holds one request and drops the next
        req_ready = 0;
        retire(32'hC0, 1, 32'hA00, 1, 1, 0);
        store(32'hA00, 32'hC0, 64'hAA);
        step(2);
        chk(req_valid && req_addr == 32'hC0, "R7 hold", 64'(req_addr), 64'hC0);
        retire(32'hC4, 1, 32'hA10, 1, 1, 0);
        store(32'hA10, 32'hC4, 64'hBB);
        chk(drop_count == 1 && req_addr == 32'hC0, "R8 drop", 64'(drop_count), 1);
        req_ready = 1;
        step();
        chk(req_valid == 0, "R7 consumed", 64'(req_valid), 0);
        step(3);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule